// File: doc/BRIEF.md
# Receive Gain Table Pointer Unit

The unit holds the gain-index pointers of one receive chain and converts them into per-stage gain control codes by reading internal constant lookup tables. The stages are a low-noise amplifier, a mixer, a transimpedance amplifier, a low-pass filter and a digital gain stage. Control logic moves the pointers by writing them directly or by asking for single steps up or down. The unit keeps each pointer inside a programmable ceiling and at or above zero.

Two table arrangements can be selected at run time. In combined mode a single pointer picks one row, and that row fixes every stage at once, so one step can change several stage codes together. In split mode the front-end stages (amplifier, mixer, transimpedance) follow one pointer and the filter follows a second pointer. When digital gain is enabled, the digital stage follows a third pointer. The gain codes are registered, and a one-cycle strobe marks every cycle in which they take a new value.

Top module: `rx_gain_ptr_unit`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, all three pointers read 0, every gain code is 0 and gain_chg_o is 0.
- R2: With split_mode_i = 0 the codes come from pointer 0 (value p). lna = p[5:4], mix = p[3:2], tia = p[1], lpf = 5 * p[1:0], and dig = {0, p[5:3]} when dig_en_i = 1.
- R3: With split_mode_i = 1, lna, mix and tia come from pointer 0 using the same bit fields as R2. lpf = min(pointer 1, 31). dig = min(pointer 2, 15) when dig_en_i = 1.
- R4: When ptr_wr_i[k] is high, pointer k loads min(ptr_wdata_i, max_k) at the next edge. Pointer 0 is the combined/front-end pointer, 1 is the filter pointer and 2 is the digital pointer. The priority is write, then step up, then step down.
- R5: When step_up_i[k] is high, pointer k increases by one, and it stays at max_k once it reaches max_k.
- R6: When step_dn_i[k] is high, pointer k decreases by one, and it stays at 0 once it reaches 0.
- R7: An active pointer that is above its ceiling, with no request pending, is clamped to the ceiling at the next edge.
- R8: In combined mode, pointers 1 and 2 ignore all requests and hold their values. In split mode with dig_en_i = 0, pointer 2 ignores all requests and holds its value.
- R9: The pointer readback changes at the edge that takes the request. The gain codes change at the edge after that.
- R10: gain_chg_o is high for exactly those cycles in which the gain codes differ from their values in the previous cycle.
- R11: With dig_en_i = 0, dig_gain_o reads 0 one cycle later, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_mode_i | input | 1 | 0 selects combined table, 1 selects split tables |
| dig_en_i | input | 1 | Enables the digital gain stage |
| ptr_wr_i | input | 3 | Per-pointer write strobes |
| ptr_wdata_i | input | 6 | Shared write value |
| step_up_i | input | 3 | Per-pointer step-up requests |
| step_dn_i | input | 3 | Per-pointer step-down requests |
| max_main_i | input | 6 | Ceiling for pointer 0 |
| max_lpf_i | input | 6 | Ceiling for pointer 1 |
| max_dig_i | input | 6 | Ceiling for pointer 2 |
| lna_gain_o | output | 2 | Amplifier gain code |
| mix_gain_o | output | 2 | Mixer gain code |
| tia_gain_o | output | 1 | Transimpedance gain code |
| lpf_gain_o | output | 5 | Filter gain code |
| dig_gain_o | output | 4 | Digital gain code |
| ptr_main_o | output | 6 | Pointer 0 readback |
| ptr_lpf_o | output | 6 | Pointer 1 readback |
| ptr_dig_o | output | 6 | Pointer 2 readback |
| gain_chg_o | output | 1 | Gain-code change strobe |

## Verification
The assertions assume that every control input is known and holds steady across each rising edge. They also assume that a ceiling sampled in one cycle is the value the pointer is judged against in the next cycle. The stimulus drives all inputs only on the falling edge. It draws the ceilings and write values over the full 6-bit range, so clamping occurs often. It switches mode and digital enable in the middle of a run, so that inactive pointers receive requests that must be ignored.

// File: rtl/rgp_pkg.sv
package rgp_pkg;
  parameter int IDX_W   = 6;
  parameter int NUM_PTR = 3;
  parameter int LNA_W   = 2;
  parameter int MIX_W   = 2;
  parameter int TIA_W   = 1;
  parameter int LPF_W   = 5;
  parameter int DIG_W   = 4;
  localparam int DEPTH  = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LPF_SAT = IDX_W'((1 << LPF_W) - 1);
  localparam logic [IDX_W-1:0] DIG_SAT = IDX_W'((1 << DIG_W) - 1);

  typedef struct packed {
    logic [LNA_W-1:0] lna;
    logic [MIX_W-1:0] mix;
    logic [TIA_W-1:0] tia;
    logic [LPF_W-1:0] lpf;
    logic [DIG_W-1:0] dig;
  } gain_codes_t;

  // combined row: mixed-radix split of the index
  function automatic gain_codes_t full_row(logic [IDX_W-1:0] i);
    gain_codes_t r;
    r.lna = i[5:4];
    r.mix = i[3:2];
    r.tia = i[1];
    r.lpf = LPF_W'(i[1:0]) * LPF_W'(5);
    r.dig = DIG_W'(i[5:3]);
    return r;
  endfunction

  function automatic gain_codes_t lmt_row(logic [IDX_W-1:0] i);
    gain_codes_t r;
    r.lna = i[5:4];
    r.mix = i[3:2];
    r.tia = i[1];
    r.lpf = '0;
    r.dig = '0;
    return r;
  endfunction

  function automatic logic [LPF_W-1:0] lpf_row(logic [IDX_W-1:0] i);
    return (i > LPF_SAT) ? LPF_SAT[LPF_W-1:0] : i[LPF_W-1:0];
  endfunction

  function automatic logic [DIG_W-1:0] dig_row(logic [IDX_W-1:0] i);
    return (i > DIG_SAT) ? DIG_SAT[DIG_W-1:0] : i[DIG_W-1:0];
  endfunction
endpackage

// File: rtl/rgp_ptr.sv
module rgp_ptr
  import rgp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wdata_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [IDX_W-1:0] max_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W:0]   cand;
  logic [IDX_W-1:0] nxt;
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    if (wr_i)                 cand = {1'b0, wdata_i};
    else if (up_i)            cand = {1'b0, ptr_q} + 1'b1;
    else if (dn_i && ptr_q != '0) cand = {1'b0, ptr_q} - 1'b1;
    else                      cand = {1'b0, ptr_q};
    nxt = (cand > {1'b0, max_i}) ? max_i : cand[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (en_i) ptr_q <= nxt;
  end

  assign ptr_o = ptr_q;

  // R7
  ptr_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (ptr_o <= $past(max_i)));

  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr_o));

  // R6
  ptr_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i && !up_i && dn_i && ptr_o == '0) |=> (ptr_o == '0));
endmodule

// File: rtl/rgp_lookup.sv
module rgp_lookup
  import rgp_pkg::*;
(
  input  logic             split_i,
  input  logic             dig_en_i,
  input  logic [IDX_W-1:0] ptr_main_i,
  input  logic [IDX_W-1:0] ptr_lpf_i,
  input  logic [IDX_W-1:0] ptr_dig_i,
  output gain_codes_t      codes_o
);
  gain_codes_t      full_tbl [DEPTH];
  gain_codes_t      lmt_tbl  [DEPTH];
  logic [LPF_W-1:0] lpf_tbl  [DEPTH];
  logic [DIG_W-1:0] dig_tbl  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign full_tbl[g] = full_row(IDX_W'(g));
    assign lmt_tbl[g]  = lmt_row(IDX_W'(g));
    assign lpf_tbl[g]  = lpf_row(IDX_W'(g));
    assign dig_tbl[g]  = dig_row(IDX_W'(g));
  end

  always_comb begin
    if (split_i) begin
      codes_o     = lmt_tbl[ptr_main_i];
      codes_o.lpf = lpf_tbl[ptr_lpf_i];
      codes_o.dig = dig_tbl[ptr_dig_i];
    end else begin
      codes_o = full_tbl[ptr_main_i];
    end
    if (!dig_en_i) codes_o.dig = '0;
  end
endmodule

// File: rtl/rx_gain_ptr_unit.sv
module rx_gain_ptr_unit
  import rgp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               split_mode_i,
  input  logic               dig_en_i,
  input  logic [NUM_PTR-1:0] ptr_wr_i,
  input  logic [IDX_W-1:0]   ptr_wdata_i,
  input  logic [NUM_PTR-1:0] step_up_i,
  input  logic [NUM_PTR-1:0] step_dn_i,
  input  logic [IDX_W-1:0]   max_main_i,
  input  logic [IDX_W-1:0]   max_lpf_i,
  input  logic [IDX_W-1:0]   max_dig_i,
  output logic [LNA_W-1:0]   lna_gain_o,
  output logic [MIX_W-1:0]   mix_gain_o,
  output logic [TIA_W-1:0]   tia_gain_o,
  output logic [LPF_W-1:0]   lpf_gain_o,
  output logic [DIG_W-1:0]   dig_gain_o,
  output logic [IDX_W-1:0]   ptr_main_o,
  output logic [IDX_W-1:0]   ptr_lpf_o,
  output logic [IDX_W-1:0]   ptr_dig_o,
  output logic               gain_chg_o
);
  logic [NUM_PTR-1:0] ptr_en;
  logic [IDX_W-1:0]   max_arr [NUM_PTR];
  logic [IDX_W-1:0]   ptr_arr [NUM_PTR];
  gain_codes_t        look;
  gain_codes_t        codes_q;
  logic               chg_q;

  // pointer 0 always live; 1 only split; 2 only split with digital gain
  assign ptr_en     = {split_mode_i & dig_en_i, split_mode_i, 1'b1};
  assign max_arr[0] = max_main_i;
  assign max_arr[1] = max_lpf_i;
  assign max_arr[2] = max_dig_i;

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    rgp_ptr u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ptr_en[k]),
      .wr_i   (ptr_wr_i[k]),
      .wdata_i(ptr_wdata_i),
      .up_i   (step_up_i[k]),
      .dn_i   (step_dn_i[k]),
      .max_i  (max_arr[k]),
      .ptr_o  (ptr_arr[k])
    );
  end

  rgp_lookup u_lookup (
    .split_i   (split_mode_i),
    .dig_en_i  (dig_en_i),
    .ptr_main_i(ptr_arr[0]),
    .ptr_lpf_i (ptr_arr[1]),
    .ptr_dig_i (ptr_arr[2]),
    .codes_o   (look)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      codes_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      codes_q <= look;
      chg_q   <= (look != codes_q);
    end
  end

  assign lna_gain_o = codes_q.lna;
  assign mix_gain_o = codes_q.mix;
  assign tia_gain_o = codes_q.tia;
  assign lpf_gain_o = codes_q.lpf;
  assign dig_gain_o = codes_q.dig;
  assign ptr_main_o = ptr_arr[0];
  assign ptr_lpf_o  = ptr_arr[1];
  assign ptr_dig_o  = ptr_arr[2];
  assign gain_chg_o = chg_q;

  // R10
  chg_moved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_chg_o |-> (codes_q != $past(codes_q)));

  // R10
  chg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gain_chg_o |-> $stable(codes_q));

  // R11
  dig_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dig_en_i |=> (dig_gain_o == '0));
endmodule

// File: tb/rx_gain_ptr_unit_tb.sv
module rx_gain_ptr_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       split_mode_i = 1'b0;
  logic       dig_en_i = 1'b1;
  logic [2:0] ptr_wr_i = '0;
  logic [5:0] ptr_wdata_i = '0;
  logic [2:0] step_up_i = '0;
  logic [2:0] step_dn_i = '0;
  logic [5:0] max_main_i = 6'd63;
  logic [5:0] max_lpf_i = 6'd63;
  logic [5:0] max_dig_i = 6'd63;
  logic [1:0] lna_gain_o;
  logic [1:0] mix_gain_o;
  logic       tia_gain_o;
  logic [4:0] lpf_gain_o;
  logic [3:0] dig_gain_o;
  logic [5:0] ptr_main_o, ptr_lpf_o, ptr_dig_o;
  logic       gain_chg_o;

  int total = 0;
  int bad = 0;
  logic [5:0]  mp [3];
  logic [13:0] prev_codes = '0;
  logic [13:0] exp_codes = '0;
  logic        exp_chg = 1'b0;

  always #10 clk_i = ~clk_i;

  rx_gain_ptr_unit u_dut (.*);

  function automatic logic [13:0] f_full(input logic [5:0] i, input logic de);
    logic [4:0] lpf;
    lpf = 5'(i[1:0]) * 5'd5;
    return {i[5:4], i[3:2], i[1], lpf, de ? {1'b0, i[5:3]} : 4'd0};
  endfunction

  function automatic logic [13:0] f_split(input logic [5:0] l, input logic [5:0] p,
                                          input logic [5:0] d, input logic de);
    logic [4:0] lpf;
    logic [3:0] dg;
    lpf = (p > 6'd31) ? 5'd31 : p[4:0];
    dg  = (d > 6'd15) ? 4'd15 : d[3:0];
    return {l[5:4], l[3:2], l[1], lpf, de ? dg : 4'd0};
  endfunction

  function automatic logic [5:0] f_nxt(input logic [5:0] p, input logic wr, input logic [5:0] wd,
                                       input logic up, input logic dn, input logic [5:0] mx);
    int c;
    if (wr) c = int'(wd);
    else if (up) c = int'(p) + 1;
    else if (dn) c = (p == 0) ? 0 : int'(p) - 1;
    else c = int'(p);
    if (c > int'(mx)) c = int'(mx);
    return 6'(c);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [13:0] dut_codes();
    return {lna_gain_o, mix_gain_o, tia_gain_o, lpf_gain_o, dig_gain_o};
  endfunction

  task automatic tick();
    logic [5:0] mx [3];
    logic [2:0] act;
    @(posedge clk_i);
    mx[0] = max_main_i; mx[1] = max_lpf_i; mx[2] = max_dig_i;
    act = {split_mode_i & dig_en_i, split_mode_i, 1'b1};
    exp_codes = split_mode_i ? f_split(mp[0], mp[1], mp[2], dig_en_i) : f_full(mp[0], dig_en_i);
    exp_chg = (exp_codes != prev_codes);
    prev_codes = exp_codes;
    for (int k = 0; k < 3; k++)
      if (act[k]) mp[k] = f_nxt(mp[k], ptr_wr_i[k], ptr_wdata_i, step_up_i[k], step_dn_i[k], mx[k]);
    @(negedge clk_i);
    chk("R4", "ptr_main", int'(ptr_main_o), int'(mp[0]));
    chk("R4", "ptr_lpf", int'(ptr_lpf_o), int'(mp[1]));
    chk("R4", "ptr_dig", int'(ptr_dig_o), int'(mp[2]));
    chk(split_mode_i ? "R3" : "R2", "codes", int'(dut_codes()), int'(exp_codes));
    chk("R10", "strobe", int'(gain_chg_o), int'(exp_chg));
  endtask

  task automatic idle();
    ptr_wr_i = '0; step_up_i = '0; step_dn_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mp[0] = '0; mp[1] = '0; mp[2] = '0;
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1", "reset ptrs", int'({ptr_main_o, ptr_lpf_o, ptr_dig_o}), 0);
    chk("R1", "reset codes", int'(dut_codes()), 0);
    chk("R1", "reset strobe", int'(gain_chg_o), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1", "first codes", int'(dut_codes()), 0);

    // R4/R9: write above ceiling, readback then codes
    max_main_i = 6'd40; ptr_wr_i = 3'b001; ptr_wdata_i = 6'd55;
    tick();
    idle();
    chk("R4", "write clamp", int'(ptr_main_o), 40);
    chk("R9", "codes lag", int'(dut_codes()), 0);
    tick();
    chk("R9", "codes follow", int'(dut_codes()), int'(f_full(6'd40, 1'b1)));
    chk("R10", "strobe on change", int'(gain_chg_o), 1);
    // R5
    step_up_i = 3'b001;
    tick(); tick();
    idle();
    chk("R5", "up at max", int'(ptr_main_o), 40);
    // R2: 3 -> 4 changes several stages
    ptr_wr_i = 3'b001; ptr_wdata_i = 6'd3;
    tick(); idle(); tick();
    step_up_i = 3'b001;
    tick(); idle(); tick();
    chk("R2", "multi-stage row 4", int'(dut_codes()), int'(f_full(6'd4, 1'b1)));
    // R6
    step_dn_i = 3'b001;
    repeat (6) tick();
    chk("R6", "down floor", int'(ptr_main_o), 0);
    step_dn_i = 3'b001; step_up_i = 3'b001;
    tick();
    chk("R4", "up over down", int'(ptr_main_o), 1);
    idle();
    // R8: combined mode ignores pointers 1 and 2
    ptr_wr_i = 3'b110; ptr_wdata_i = 6'd20;
    tick(); idle();
    chk("R8", "lpf hold", int'(ptr_lpf_o), 0);
    chk("R8", "dig hold", int'(ptr_dig_o), 0);
    // R3 / R8 split, digital off
    split_mode_i = 1'b1; dig_en_i = 1'b0;
    ptr_wr_i = 3'b110; ptr_wdata_i = 6'd40;
    tick(); idle(); tick();
    chk("R8", "dig hold split", int'(ptr_dig_o), 0);
    chk("R3", "lpf sat", int'(lpf_gain_o), 31);
    chk("R11", "dig off", int'(dig_gain_o), 0);
    dig_en_i = 1'b1; ptr_wr_i = 3'b100; ptr_wdata_i = 6'd20;
    tick(); idle(); tick();
    chk("R3", "dig sat", int'(dig_gain_o), 15);
    dig_en_i = 1'b0;
    tick();
    chk("R11", "dig off again", int'(dig_gain_o), 0);
    // R7
    ptr_wr_i = 3'b001; ptr_wdata_i = 6'd30;
    tick(); idle();
    max_main_i = 6'd10;
    tick();
    chk("R7", "ceiling lowered", int'(ptr_main_o), 10);

    for (int n = 0; n < 4000; n++) begin
      split_mode_i = ($urandom % 4) != 0;
      dig_en_i     = ($urandom % 3) != 0;
      ptr_wr_i     = 3'($urandom % 8) & 3'($urandom % 8);
      step_up_i    = 3'($urandom % 8);
      step_dn_i    = 3'($urandom % 8);
      ptr_wdata_i  = 6'($urandom);
      if ($urandom % 16 == 0) begin
        max_main_i = 6'($urandom);
        max_lpf_i  = 6'($urandom);
        max_dig_i  = 6'($urandom);
      end
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule